// File: doc/BRIEF.md
# Multicycle Harvard Register-File Processor Core

A compact multicycle processor that keeps program and data in two separate synchronous memories. Every instruction passes through a fetch phase (the program counter addresses the instruction ROM), a decode phase (the returned word is captured in the instruction register) and an execute phase, in which operands are read from a sixteen-entry register file, the arithmetic unit computes the result and the program counter advances. Loads and stores add a memory phase driven from a memory address register and a memory buffer register; loads add one more phase to write the returned word back.

The core has no flags. A compare writes a three-valued signed result (-1, 0, +1) into a two-bit comparison register. A conditional jump carries its own small signed constant and is taken only when that constant equals the stored result. The core runs from reset until it fetches from an index outside the program, then raises a sticky halted output and freezes.

Top module: `mc_core`

## Requirements
- R1: While and after reset (active high, synchronous), the program counter, all sixteen registers and the comparison register are zero, halted and dmem_we are low, and imem_addr is 0.
- R2: An instruction word is 29 bits: opcode [28:25], immediate-select [24], first register A [23:20], second register B [19:16], 16-bit signed immediate or target [15:0]; three-register arithmetic takes its third register C from [15:12]. Opcodes: 0 load, 1 store, 2 move, 3 add, 4 subtract, 5 multiply, 6 divide, 7 increment, 8 decrement, 9 compare, 10 conditional jump, 11 unconditional jump; codes 12 to 15 do nothing but advance the program counter.
- R3: Move writes register A with the immediate when immediate-select is 1, else with register B.
- R4: Add, subtract and multiply write register A with B op C, wrapped to 16-bit two's complement.
- R5: Divide writes register A with B / C as a signed quotient truncated toward zero and wrapped to 16 bits; a zero divisor writes 0.
- R6: Increment and decrement add or subtract one to register A, with 16-bit wrap.
- R7: Load writes register A with the data word at the address given by the immediate (select 1) or by register B (select 0), using the low data-address bits.
- R8: Store writes register A to the address chosen as in R7, as a single-cycle write strobe.
- R9: Compare sets the comparison register to -1, 0 or +1 as register A is less than, equal to or greater than (signed) the immediate or register B, and changes no general register.
- R10: A conditional jump loads the target field into the program counter only when its field B, read as a 4-bit signed constant, equals the comparison register; otherwise it falls through.
- R11: An unconditional jump always loads the target field into the program counter.
- R12: A fetch with the program counter (unsigned 16-bit) at or above PROG_LEN raises halted one cycle later; halted stays high and no further data writes occur until reset.
- R13: An instruction takes 3 clock cycles, a store 4 and a load 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; releasing it starts execution at index 0 |
| imem_addr | output | IAW | Instruction ROM address (program counter) |
| imem_rdata | input | 29 | Instruction ROM data, valid one cycle after the address |
| dmem_addr | output | DAW | Data RAM address |
| dmem_wdata | output | 16 | Data RAM write data |
| dmem_we | output | 1 | Data RAM write strobe |
| dmem_rdata | input | 16 | Data RAM read data, valid one cycle after the address |
| halted | output | 1 | High once the core has stopped |

## Verification
Each arithmetic opcode runs in a short program with operand pairs chosen so that sum and difference overflow, products exceed sixteen bits, quotients of negative dividends show truncation toward zero, and the zero-divisor and most-negative-by-minus-one cases are separated from ordinary division. Compare and conditional jump are tried over less, equal and greater operand pairs in both immediate and register form, against jump constants that match, mismatch, and that can never match, which distinguishes a signed three-valued result from a plain equality flag. Load and store use both addressing forms in one program, and the halt boundary is probed one index below, exactly at and far beyond the program length, alongside cycle counts that reveal any extra or missing phase.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int WORD_W  = 16;
  localparam int INSTR_W = 29;
  localparam int RIDX_W  = 4;
  localparam int NUM_REGS = 1 << RIDX_W;

  localparam logic [3:0] OPC_LOAD  = 4'd0;
  localparam logic [3:0] OPC_STORE = 4'd1;
  localparam logic [3:0] OPC_MOVE  = 4'd2;
  localparam logic [3:0] OPC_ADD   = 4'd3;
  localparam logic [3:0] OPC_SUB   = 4'd4;
  localparam logic [3:0] OPC_MUL   = 4'd5;
  localparam logic [3:0] OPC_DIV   = 4'd6;
  localparam logic [3:0] OPC_INC   = 4'd7;
  localparam logic [3:0] OPC_DEC   = 4'd8;
  localparam logic [3:0] OPC_CMP   = 4'd9;
  localparam logic [3:0] OPC_JMPC  = 4'd10;
  localparam logic [3:0] OPC_JMPU  = 4'd11;

  typedef logic signed [WORD_W-1:0] word_t;
  typedef logic signed [1:0]        cmp_t;

  typedef struct packed {
    logic [3:0]        opc;
    logic              imm_sel;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [WORD_W-1:0] imm;
  } instr_t;

  typedef enum logic [2:0] {
    PH_FETCH, PH_DECODE, PH_EXEC, PH_MEM, PH_WB, PH_HALT
  } phase_e;

  function automatic logic is_arith(logic [3:0] opc);
    return (opc == OPC_ADD) || (opc == OPC_SUB) ||
           (opc == OPC_MUL) || (opc == OPC_DIV);
  endfunction

  function automatic logic writes_reg(logic [3:0] opc);
    return is_arith(opc) || (opc == OPC_MOVE) ||
           (opc == OPC_INC) || (opc == OPC_DEC);
  endfunction

  // Arithmetic result, all cases wrapped to WORD_W bits.
  function automatic word_t alu_calc(logic [3:0] opc, word_t x, word_t y);
    logic signed [WORD_W:0] xw;
    logic signed [WORD_W:0] yw;
    logic signed [WORD_W:0] qw;
    word_t r;
    xw = {x[WORD_W-1], x};
    yw = {y[WORD_W-1], y};
    qw = '0;
    r  = x;
    case (opc)
      OPC_ADD:  r = x + y;
      OPC_SUB:  r = x - y;
      OPC_MUL:  r = x * y;
      OPC_DIV: begin
        if (y == '0) begin
          r = '0;
        end else begin
          qw = xw / yw;
          r  = qw[WORD_W-1:0];
        end
      end
      OPC_INC:  r = x + word_t'(1);
      OPC_DEC:  r = x - word_t'(1);
      OPC_MOVE: r = y;
      default:  r = x;
    endcase
    return r;
  endfunction

  // Three-valued signed ordering of x against y.
  function automatic cmp_t cmp3(word_t x, word_t y);
    if (x < y)       return 2'sb11;
    else if (x == y) return 2'sb00;
    else             return 2'sb01;
  endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int NREGS = 16,
  parameter int W     = 16,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NRD-1:0][AW-1:0]  rd_idx,
  output logic [NRD-1:0][W-1:0]   rd_data,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_idx,
  input  logic [W-1:0]            wr_data
);

  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = regs[rd_idx[p]];
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  logic [3:0] opc,
  input  word_t      x,
  input  word_t      y,
  output word_t      result,
  output cmp_t       order
);

  assign result = alu_calc(opc, x, y);
  assign order  = cmp3(x, y);

endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pc_beyond,
  input  logic mem_op,
  input  logic load_op,
  output logic ir_en,
  output logic exec_en,
  output logic mem_en,
  output logic wb_en,
  output logic fetch_now,
  output logic halted
);

  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_FETCH:  ph_d = pc_beyond ? PH_HALT : PH_DECODE;
      PH_DECODE: ph_d = PH_EXEC;
      PH_EXEC:   ph_d = mem_op ? PH_MEM : PH_FETCH;
      PH_MEM:    ph_d = load_op ? PH_WB : PH_FETCH;
      PH_WB:     ph_d = PH_FETCH;
      PH_HALT:   ph_d = PH_HALT;
      default:   ph_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_FETCH;
    else     ph_q <= ph_d;
  end

  assign fetch_now = (ph_q == PH_FETCH);
  assign ir_en     = (ph_q == PH_DECODE);
  assign exec_en   = (ph_q == PH_EXEC);
  assign mem_en    = (ph_q == PH_MEM);
  assign wb_en     = (ph_q == PH_WB);
  assign halted    = (ph_q == PH_HALT);

  // R12
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_now && pc_beyond) |=> halted);

  // R12
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int IAW      = 8,
  parameter int DAW      = 8,
  parameter int PROG_LEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IAW-1:0]     imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [DAW-1:0]     dmem_addr,
  output logic [WORD_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [WORD_W-1:0]  dmem_rdata,
  output logic               halted
);

  localparam int PC_W = WORD_W;
  localparam logic [PC_W-1:0] PC_LIMIT = PC_W'(PROG_LEN);

  logic [PC_W-1:0] pc_q;
  instr_t          ir_q;
  logic [DAW-1:0]  mar_q;
  word_t           mbr_q;
  cmp_t            cr_q;

  // Named internal events
  logic ir_en, exec_en, mem_en, wb_en, fetch_now;
  logic pc_beyond, mem_op, load_op, store_op, cmp_op, jump_hit;
  logic rf_we;
  logic [PC_W-1:0] pc_next;

  logic [2:0][RIDX_W-1:0] rd_idx;
  logic [2:0][WORD_W-1:0] rd_data;
  word_t r_a, r_b, r_c, opnd2, alu_x, alu_y, alu_res, rf_wdata;
  cmp_t  alu_order;

  assign pc_beyond = (pc_q >= PC_LIMIT);
  assign mem_op    = (ir_q.opc == OPC_LOAD) || (ir_q.opc == OPC_STORE);
  assign load_op   = (ir_q.opc == OPC_LOAD);
  assign store_op  = (ir_q.opc == OPC_STORE);
  assign cmp_op    = (ir_q.opc == OPC_CMP);

  mc_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .pc_beyond (pc_beyond),
    .mem_op    (mem_op),
    .load_op   (load_op),
    .ir_en     (ir_en),
    .exec_en   (exec_en),
    .mem_en    (mem_en),
    .wb_en     (wb_en),
    .fetch_now (fetch_now),
    .halted    (halted)
  );

  // Operand selection
  assign rd_idx[0] = ir_q.ra;
  assign rd_idx[1] = ir_q.rb;
  assign rd_idx[2] = ir_q.imm[WORD_W-1 -: RIDX_W];

  assign r_a   = word_t'(rd_data[0]);
  assign r_b   = word_t'(rd_data[1]);
  assign r_c   = word_t'(rd_data[2]);
  assign opnd2 = ir_q.imm_sel ? word_t'(ir_q.imm) : r_b;
  assign alu_x = is_arith(ir_q.opc) ? r_b : r_a;
  assign alu_y = is_arith(ir_q.opc) ? r_c : opnd2;

  mc_alu u_alu (
    .opc    (ir_q.opc),
    .x      (alu_x),
    .y      (alu_y),
    .result (alu_res),
    .order  (alu_order)
  );

  assign rf_we    = (exec_en && writes_reg(ir_q.opc)) || (wb_en && load_op);
  assign rf_wdata = wb_en ? word_t'(dmem_rdata) : alu_res;

  mc_regfile #(
    .NREGS (NUM_REGS),
    .W     (WORD_W),
    .NRD   (3)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wr_en   (rf_we),
    .wr_idx  (ir_q.ra),
    .wr_data (rf_wdata)
  );

  // Jump decision: 4-bit signed constant against the sign-extended result
  assign jump_hit = (ir_q.rb == {{(RIDX_W-2){cr_q[1]}}, cr_q});

  always_comb begin
    pc_next = pc_q + PC_W'(1);
    if (ir_q.opc == OPC_JMPU) pc_next = ir_q.imm;
    else if (ir_q.opc == OPC_JMPC && jump_hit) pc_next = ir_q.imm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      cr_q  <= '0;
    end else begin
      if (ir_en) ir_q <= instr_t'(imem_rdata);
      if (exec_en) begin
        pc_q <= pc_next;
        if (cmp_op) cr_q <= alu_order;
        if (mem_op) begin
          mar_q <= opnd2[DAW-1:0];
          mbr_q <= r_a;
        end
      end
      if (wb_en) mbr_q <= word_t'(dmem_rdata);
    end
  end

  assign imem_addr  = pc_q[IAW-1:0];
  assign dmem_addr  = mar_q;
  assign dmem_wdata = mbr_q;
  assign dmem_we    = mem_en && store_op;

  // R8
  store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !dmem_we);

  // R13
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(pc_q));

  // R9
  cmp_range_chk: assert property (@(posedge clk) disable iff (rst)
    cr_q != 2'sb10);

  // R12
  halt_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !dmem_we);

endmodule

// File: tb/mc_core_test.sv
module mc_core_test;

  localparam int ROM_N = 32;
  localparam int RAM_N = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr;
  logic [28:0] imem_rdata;
  logic [7:0]  dmem_addr;
  logic [15:0] dmem_wdata;
  logic        dmem_we;
  logic [15:0] dmem_rdata;
  logic        halted;

  logic [28:0] rom [ROM_N];
  logic [15:0] ram [RAM_N];
  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;

  int checks = 0;
  int fails  = 0;
  int we_count = 0;
  int last_waddr = 0;
  int last_wdata = 0;

  always #10 clk = ~clk;

  mc_core uut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .halted     (halted)
  );

  always @(posedge clk) imem_rdata <= rom[imem_addr[4:0]];

  always @(posedge clk) begin
    if (ld_we) ram[ld_addr] <= ld_data;
    else if (dmem_we) ram[dmem_addr] <= dmem_wdata;
    dmem_rdata <= ram[dmem_addr];
  end

  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      we_count   <= we_count + 1;
      last_waddr <= int'(dmem_addr);
      last_wdata <= int'(dmem_wdata);
    end
  end

  function automatic logic [28:0] enc(int op, int isel, int ra, int rb, int imm);
    return {op[3:0], isel[0], ra[3:0], rb[3:0], imm[15:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < ROM_N; i++) rom[i] = enc(11, 1, 0, 0, 100);
  endtask

  task automatic poke(int a, int d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a[7:0]; ld_data = d[15:0];
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic clear_ram();
    for (int i = 0; i < RAM_N; i++) poke(i, 0);
  endtask

  task automatic run_prog(output int cyc);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 500) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 500) chk("R12 timeout", cyc, -1);
  endtask

  function automatic int rd(int a);
    return int'($signed(ram[a]));
  endfunction

  // Arithmetic vectors: opcode, a, b, expected result
  localparam int NV = 16;
  localparam int V_OP  [NV] = '{3, 3, 4, 4, 5, 5, 5, 6, 6, 6, 6, 7, 7, 8, 8, 15};
  localparam int V_A   [NV] = '{100, 32767, 5, -32768, 300, 256, 1000, 100,
                                -100, 55, -32768, 41, 32767, 0, -5, 1234};
  localparam int V_B   [NV] = '{23, 1, 9, 1, -7, 256, 100, 7,
                                7, 0, -1, 0, 0, 0, 0, 0};
  localparam int V_EXP [NV] = '{123, -32768, -4, 32767, -2100, 0, -31072, 14,
                                -14, 0, -32768, 42, -32768, -1, -6, 1234};

  // Compare / conditional jump vectors: a, b, const, register form, marker
  localparam int NC = 9;
  localparam int C_A   [NC] = '{3, 3, 8, 9, 9, -5, 4, 7, 9};
  localparam int C_B   [NC] = '{8, 8, 8, 8, 8, 2, 4, -3, 8};
  localparam int C_K   [NC] = '{-1, 0, 0, 1, -1, -1, 0, 1, 5};
  localparam int C_REG [NC] = '{0, 0, 0, 0, 0, 0, 1, 1, 0};
  localparam int C_EXP [NC] = '{0, 1, 0, 0, 1, 0, 0, 0, 1};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int cyc;
    int w0;
    string tag;
    clear_rom();

    // R1: outputs while in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 dmem_we in reset", int'(dmem_we), 0);
    chk("R1 imem_addr in reset", int'(imem_addr), 0);

    clear_ram();

    // Arithmetic vector walk (R3 register move, R4, R5, R6, R2 unused opcodes)
    for (int i = 0; i < NV; i++) begin
      clear_rom();
      rom[0] = enc(2, 1, 1, 0, V_A[i]);
      rom[1] = enc(2, 1, 2, 0, V_B[i]);
      rom[2] = enc(2, 0, 3, 1, 0);
      if (V_OP[i] >= 3 && V_OP[i] <= 6) rom[3] = enc(V_OP[i], 0, 3, 1, 2 << 12);
      else rom[3] = enc(V_OP[i], 0, 3, 0, 0);
      rom[4] = enc(1, 1, 3, 0, 90);
      rom[5] = enc(11, 1, 0, 0, 100);
      run_prog(cyc);
      case (V_OP[i])
        3, 4, 5: tag = "R4 add/sub/mul";
        6:       tag = "R5 divide";
        7, 8:    tag = "R6 inc/dec";
        default: tag = "R2 unused opcode / R3 move";
      endcase
      chk($sformatf("%s vector %0d", tag, i), rd(90), V_EXP[i]);
    end

    // Compare and conditional jump (R9, R10)
    for (int i = 0; i < NC; i++) begin
      clear_rom();
      rom[0] = enc(2, 1, 1, 0, C_A[i]);
      rom[1] = enc(2, 1, 2, 0, C_B[i]);
      rom[2] = C_REG[i] != 0 ? enc(9, 0, 1, 2, 0) : enc(9, 1, 1, 0, C_B[i]);
      rom[3] = enc(10, 1, 0, C_K[i], 5);
      rom[4] = enc(2, 1, 4, 0, 1);
      rom[5] = enc(1, 1, 4, 0, 80);
      rom[6] = enc(1, 1, 1, 0, 81);
      rom[7] = enc(11, 1, 0, 0, 100);
      run_prog(cyc);
      chk($sformatf("R10 jump decision case %0d", i), rd(80), C_EXP[i]);
      chk($sformatf("R9 compare keeps register case %0d", i), rd(81), C_A[i]);
    end

    // R1: registers and comparison register zero after reset
    clear_rom();
    poke(82, 55);
    rom[0] = enc(10, 1, 0, 0, 2);
    rom[1] = enc(2, 1, 4, 0, 1);
    rom[2] = enc(1, 1, 4, 0, 80);
    rom[3] = enc(1, 1, 7, 0, 82);
    run_prog(cyc);
    chk("R1 comparison register zero", rd(80), 0);
    chk("R1 register zero", rd(82), 0);

    // R7 / R8: both address forms
    clear_rom();
    poke(150, 777);
    poke(151, -3);
    poke(152, 0);
    rom[0] = enc(2, 1, 2, 0, 151);
    rom[1] = enc(0, 1, 1, 0, 150);
    rom[2] = enc(0, 0, 3, 2, 0);
    rom[3] = enc(3, 0, 4, 1, 3 << 12);
    rom[4] = enc(1, 0, 4, 2, 0);
    rom[5] = enc(1, 1, 1, 0, 152);
    run_prog(cyc);
    chk("R7 R8 register-addressed load/store", rd(151), 774);
    chk("R7 R8 constant-addressed load/store", rd(152), 777);

    // R13 cycle counts and R8 single strobe
    clear_rom();
    rom[0] = enc(2, 1, 1, 0, 5);
    run_prog(cyc);
    chk("R13 plain instruction cycles", cyc, 7);
    clear_rom();
    rom[0] = enc(2, 1, 1, 0, 0);
    rom[0] = enc(1, 1, 1, 0, 10);
    w0 = we_count;
    run_prog(cyc);
    chk("R13 store cycles", cyc, 8);
    chk("R8 single write strobe", we_count - w0, 1);
    chk("R8 write address", last_waddr, 10);
    clear_rom();
    rom[0] = enc(0, 1, 1, 0, 10);
    run_prog(cyc);
    chk("R13 load cycles", cyc, 9);

    // R12 halt boundary, R11 jumps
    clear_rom();
    poke(60, 0);
    rom[0]  = enc(2, 1, 1, 0, 9);
    rom[1]  = enc(11, 1, 0, 0, 31);
    rom[31] = enc(1, 1, 1, 0, 60);
    run_prog(cyc);
    chk("R11 R12 last valid index executes", rd(60), 9);
    chk("R12 halt after last index cycles", cyc, 11);
    w0 = we_count;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R12 halted sticky", int'(halted), 1);
    chk("R12 no writes after halt", we_count - w0, 0);

    clear_rom();
    poke(61, 5);
    rom[0] = enc(11, 1, 0, 0, 32);
    rom[1] = enc(1, 1, 1, 0, 61);
    run_prog(cyc);
    chk("R12 jump to PROG_LEN halts", cyc, 4);
    chk("R11 jump skips fall-through store", rd(61), 5);

    clear_rom();
    rom[0] = enc(11, 1, 0, 0, -1);
    run_prog(cyc);
    chk("R12 negative target halts", cyc, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule